// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digitized supply-good flag and a watchdog timeout pulse into a registered, active-low system reset. The same reset also gates the serial port of an attached nonvolatile memory. The supply flag comes from an analog comparator and arrives asynchronously, so it passes through a synchronizer first. A low level, or a watchdog pulse, puts the block into its hold phase. Reset is released only after the synchronized flag has stayed high, with no timeout, for a programmable number of clock cycles. The default count gives 200 ms at 100 MHz.

Reset can become active while a serial transfer is running. In that case the block issues a single-cycle abort pulse to terminate the transfer. While reset stays active, every request to start a transfer or a nonvolatile write is refused. A write that is already running is never interrupted: no output of the block can stop a write that has started, and the write-busy flag plays no part in the reset timing. It only refuses a second write start while one is running.

Top module: `supply_rst_seq`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n`, `xfer_abort`, `xfer_grant` and `nvw_grant` are all 0, whatever the request inputs are.
- R2: After power-up, if `vok_raw` is high at every rising edge from edge e onward and no watchdog pulse arrives, `sys_rst_n` stays 0 through edge e+HOLD_CYCLES and becomes 1 after edge e+HOLD_CYCLES+1.
- R3: A `vok_raw` low sampled at edge j drives `sys_rst_n` to 0 after edge j+2. Reset is then released no earlier than after edge j+HOLD_CYCLES+2, and a single low sample is enough to restart the full interval.
- R4: A `wdt_expire` high sampled at edge j drives `sys_rst_n` to 0 after that edge. With the supply good, release follows after edge j+HOLD_CYCLES. A further pulse during the hold restarts the interval from that pulse.
- R5: `xfer_abort` is 1 for exactly the one cycle after the edge at which `sys_rst_n` goes from 1 to 0, and only if `xfer_active` was 1 at that edge. It is 0 at all other times.
- R6: `xfer_grant` equals `xfer_req` while `sys_rst_n` is 1 and is 0 while `sys_rst_n` is 0.
- R7: `nvw_grant` is 1 only when `nvw_req` is 1, `sys_rst_n` is 1 and `nvw_busy` is 0.
- R8: `nvw_busy` has no effect on `sys_rst_n` or `xfer_abort`, so a write that is running when reset asserts is never aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-application reset, active low |
| vok_raw | input | 1 | Asynchronous comparator flag, 1 = supply above threshold |
| wdt_expire | input | 1 | Synchronous watchdog timeout pulse |
| xfer_active | input | 1 | A serial transaction is in progress |
| xfer_req | input | 1 | Request to accept a new serial transaction |
| nvw_busy | input | 1 | A nonvolatile write is running |
| nvw_req | input | 1 | Request to start a nonvolatile write |
| sys_rst_n | output | 1 | Registered system reset, active low |
| xfer_abort | output | 1 | One-cycle pulse that terminates the running transaction |
| xfer_grant | output | 1 | New transaction accepted |
| nvw_grant | output | 1 | Nonvolatile write start allowed |

## Verification
The bench uses a hold of 6 cycles and runs four stimulus families.

- **Plain power-up ramp.** This pins the exact release edge.
- **Single-cycle supply dip, swept across every hold position and past release.** This separates a counter that restarts from one that merely pauses. It also shows the two-edge synchronizer latency at every point.
- **Watchdog pulse pair, with the second pulse swept over the hold.** This distinguishes watchdog restarts from supply restarts, which have a different latency.
- **Long brownout with the write-busy flag held high and no transfer running.** This shows that a running write neither delays release nor draws an abort.

Transfer-active, request and busy flags are varied across all four families. As a result, abort and both grants are compared on every edge against the expected reset level.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

    // Flop stages on the asynchronous comparator flag.
    localparam int SYNC_STAGES = 2;

    // Phase value doubles as the active-low reset level.
    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } sup_phase_e;

endpackage

// File: rtl/vok_sync.sv
module vok_sync
    import supply_rst_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);

    logic [SYNC_STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[SYNC_STAGES-2:0], din};
    end

    // Reset to 0: the supply is treated as bad until it has been seen.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign dout = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import supply_rst_pkg::*;
#(
    parameter int HOLD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic vok_s,
    input  logic wdt_expire,
    output logic run_o,
    output logic enter_o
);

    localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        sup_phase_e      phase;
        logic [CNT_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!vok_s || wdt_expire) begin
            // Any bad sample or timeout restarts the whole interval.
            st_d.phase = PH_HOLD;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_HOLD) begin
            if (st_q.cnt == LAST) st_d.phase = PH_RUN;
            else                  st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{phase: PH_HOLD, cnt: '0};
        else         st_q <= st_d;
    end

    assign run_o   = st_q.phase;
    assign enter_o = (st_q.phase == PH_RUN) && (st_d.phase == PH_HOLD);

endmodule

// File: rtl/xfer_gate.sv
module xfer_gate (
    input  logic clk,
    input  logic arst_n,
    input  logic run_i,
    input  logic enter_i,
    input  logic xfer_active,
    input  logic xfer_req,
    input  logic nvw_busy,
    input  logic nvw_req,
    output logic xfer_abort,
    output logic xfer_grant,
    output logic nvw_grant
);

    typedef struct packed {
        logic abort;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        // Only the serial transfer is terminated; a running write is left alone.
        st_d.abort = enter_i && xfer_active;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{abort: 1'b0};
        else         st_q <= st_d;
    end

    assign xfer_abort = st_q.abort;
    assign xfer_grant = xfer_req && run_i;
    assign nvw_grant  = nvw_req && run_i && !nvw_busy;

endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq #(
    parameter int HOLD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic vok_raw,
    input  logic wdt_expire,
    input  logic xfer_active,
    input  logic xfer_req,
    input  logic nvw_busy,
    input  logic nvw_req,
    output logic sys_rst_n,
    output logic xfer_abort,
    output logic xfer_grant,
    output logic nvw_grant
);

    logic vok_s;
    logic run;
    logic enter;

    vok_sync u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (vok_raw),
        .dout   (vok_s)
    );

    hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk        (clk),
        .arst_n     (arst_n),
        .vok_s      (vok_s),
        .wdt_expire (wdt_expire),
        .run_o      (run),
        .enter_o    (enter)
    );

    xfer_gate u_gate (
        .clk         (clk),
        .arst_n      (arst_n),
        .run_i       (run),
        .enter_i     (enter),
        .xfer_active (xfer_active),
        .xfer_req    (xfer_req),
        .nvw_busy    (nvw_busy),
        .nvw_req     (nvw_req),
        .xfer_abort  (xfer_abort),
        .xfer_grant  (xfer_grant),
        .nvw_grant   (nvw_grant)
    );

    assign sys_rst_n = run;

endmodule

// File: rtl/supply_rst_seq_chk.sv
module supply_rst_seq_chk (
    input logic clk,
    input logic arst_n,
    input logic vok_raw,
    input logic wdt_expire,
    input logic xfer_active,
    input logic xfer_req,
    input logic nvw_busy,
    input logic nvw_req,
    input logic sys_rst_n,
    input logic xfer_abort,
    input logic xfer_grant,
    input logic nvw_grant
);

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
        xfer_abort |=> !xfer_abort); // R5

    AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (!arst_n)
        xfer_abort |-> (!sys_rst_n && $past(sys_rst_n) && $past(xfer_active))); // R5

    AST_WDT_RESETS: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_expire |=> !sys_rst_n); // R4

    AST_RELEASE_SUPPLY_OK: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n) |-> ($past(vok_raw, 3) && $past(vok_raw, 4) && !$past(wdt_expire))); // R2

    AST_NO_XFER_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
        !sys_rst_n |-> !xfer_grant); // R6

    AST_NO_NVW_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
        (!sys_rst_n || nvw_busy) |-> !nvw_grant); // R7

    AST_XFER_PASS: assert property (@(posedge clk) disable iff (!arst_n)
        (sys_rst_n && xfer_req) |-> xfer_grant); // R6

    always_comb begin
        if (!arst_n) begin
            AST_RESET_QUIET: assert (!sys_rst_n && !xfer_abort); // R1
        end
    end

endmodule

bind supply_rst_seq supply_rst_seq_chk u_chk (
    .clk         (clk),
    .arst_n      (arst_n),
    .vok_raw     (vok_raw),
    .wdt_expire  (wdt_expire),
    .xfer_active (xfer_active),
    .xfer_req    (xfer_req),
    .nvw_busy    (nvw_busy),
    .nvw_req     (nvw_req),
    .sys_rst_n   (sys_rst_n),
    .xfer_abort  (xfer_abort),
    .xfer_grant  (xfer_grant),
    .nvw_grant   (nvw_grant)
);

// File: tb/supply_rst_seq_bench.sv
`timescale 1ns/1ps
module supply_rst_seq_bench;

    localparam int HOLD = 6;
    localparam int HIST = 2048;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic vok_raw = 1'b0;
    logic wdt_expire = 1'b0;
    logic xfer_active = 1'b0;
    logic xfer_req = 1'b0;
    logic nvw_busy = 1'b0;
    logic nvw_req = 1'b0;
    logic sys_rst_n, xfer_abort, xfer_grant, nvw_grant;

    int n_checks = 0;
    int n_fail = 0;
    int edge_no = 0;
    bit low_h [0:HIST-1];
    bit wdt_h [0:HIST-1];
    bit xa_h  [0:HIST-1];

    always #5 clk = ~clk;

    supply_rst_seq #(.HOLD_CYCLES(HOLD)) u_supply_rst_seq (
        .clk(clk), .arst_n(arst_n), .vok_raw(vok_raw), .wdt_expire(wdt_expire),
        .xfer_active(xfer_active), .xfer_req(xfer_req), .nvw_busy(nvw_busy),
        .nvw_req(nvw_req), .sys_rst_n(sys_rst_n), .xfer_abort(xfer_abort),
        .xfer_grant(xfer_grant), .nvw_grant(nvw_grant)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual %b expected %b", tag, edge_no, act, exp);
        end
    endtask

    // Reset expected active after edge i: a low sampled at j holds over
    // [j+2, j+HOLD+1]; a timeout at j holds over [j, j+HOLD-1].
    function automatic bit exp_active(input int i);
        if (i < HOLD + 2) return 1'b1;
        for (int j = i - HOLD - 1; j <= i - 2; j++)
            if (low_h[j]) return 1'b1;
        for (int j = i - HOLD + 1; j <= i; j++)
            if (wdt_h[j]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input logic raw, input logic wdt, input logic xa,
                        input logic xr, input logic nb, input logic nr, input string tag);
        bit act_now, act_prev;
        vok_raw = raw; wdt_expire = wdt; xfer_active = xa;
        xfer_req = xr; nvw_busy = nb; nvw_req = nr;
        @(posedge clk);
        edge_no++;
        if (edge_no < HIST) begin
            low_h[edge_no] = !raw;
            wdt_h[edge_no] = wdt;
            xa_h[edge_no]  = xa;
        end
        #1;
        act_now  = exp_active(edge_no);
        act_prev = (edge_no <= 1) ? 1'b1 : exp_active(edge_no - 1);
        check(tag, sys_rst_n, !act_now);
        check({"R5/", tag}, xfer_abort, act_now && !act_prev && xa_h[edge_no]);
        check("R6", xfer_grant, xr && !act_now);
        check("R7", nvw_grant, nr && !act_now && !nb);
    endtask

    initial begin
        fork
            begin
                #(200000 * 10);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                // R1: quiet during reset, with requests asserted
                xfer_req = 1'b1; nvw_req = 1'b1; xfer_active = 1'b1; vok_raw = 1'b1;
                repeat (3) @(posedge clk);
                #1;
                check("R1", sys_rst_n, 1'b0);
                check("R1", xfer_abort, 1'b0);
                check("R1", xfer_grant, 1'b0);
                check("R1", nvw_grant, 1'b0);
                low_h[0] = 1'b1;
                arst_n = 1'b1;

                // R2: power-up ramp, supply good from edge 1
                for (int k = 0; k < HOLD + 6; k++)
                    step(1'b1, 1'b0, 1'b1, 1'b1, k[0], 1'b1, "R2");

                // R3: one-cycle dip swept over the hold and beyond release
                for (int p = 0; p <= HOLD + 2; p++) begin
                    step(1'b0, 1'b0, p[0], 1'b1, p[1], 1'b1, "R3");
                    for (int k = 0; k < p; k++)
                        step(1'b1, 1'b0, k[0], k[1], p[1], 1'b1, "R3");
                    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
                    for (int k = 0; k < HOLD + 4; k++)
                        step(1'b1, 1'b0, 1'b1, 1'b1, k[0], k[1], "R3");
                end

                // R4: timeout pairs, second pulse swept over the hold
                for (int p = 1; p <= HOLD + 2; p++) begin
                    step(1'b1, 1'b1, !p[0], 1'b1, 1'b0, 1'b1, "R4");
                    for (int k = 0; k < p - 1; k++)
                        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
                    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
                    for (int k = 0; k < HOLD + 2; k++)
                        step(1'b1, 1'b0, 1'b0, k[0], 1'b0, 1'b1, "R4");
                end

                // R8: brownout during a running write, no transfer in flight
                for (int k = 0; k < 5; k++)
                    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
                for (int k = 0; k < HOLD + 4; k++)
                    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
                for (int k = 0; k < 3; k++)
                    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule